// File: doc/BRIEF.md
# Procedure Exit Return Sequencer

This block performs the return half of a procedure exit on a stack machine. When `start` is pulsed, it latches the current Q, S and P registers, the code-bounds pair, the caller's mode, the table flags of the return code segment, and the count of parameters to discard. It then fetches the four-word stack marker that ends at Q. The fetch uses a request/acknowledge read port that may stall for any number of cycles.

Once the marker is in hand, the block spends one cycle on the checks. It signals that the segment table entry has been examined, then evaluates four trap conditions in a fixed priority. If any condition holds, it reports exactly one trap code and leaves every architectural output untouched. Otherwise it restores the index, status, Q, S and P registers in one edge and pulses `done`. The trap handlers, segment loading and the call side that builds the marker lie outside the block.

Top module: `proc_exit_seq`

## Requirements
- R1: After synchronous reset, all register outputs are zero, and `mk_req`, `ref_mark`, `done` and `trap_valid` are low.
- R2: The marker is read one word at a time, at addresses Q-3, Q-2, Q-1 and Q in that order, where Q is the value latched at start. The words are, in order: saved index, return offset word, saved status, and Q offset. While `mk_req` is high and `mk_ack` is low, `mk_addr` holds steady.
- R3: A privilege trap (code 1) is raised when `user_mode` and `seg_priv` are both set. In privileged mode, `seg_priv` has no effect.
- R4: An absent-segment trap (code 2) is raised when `seg_absent` is set and no privilege trap applies.
- R5: A trace trap (code 3) is raised when the most significant bit of the return offset word is set and no earlier trap applies.
- R6: The return address is P minus the lower W-1 bits of the return offset word, modulo 2^W. If it lies outside the range from `bound_lo` to `bound_hi` inclusive, a bounds trap (code 4) is raised, provided no earlier trap applies.
- R7: `ref_mark` pulses for exactly one cycle per accepted exit, after the last marker word arrives, whether the exit traps or succeeds.
- R8: A trap is reported as a one-cycle `trap_valid` pulse that carries its single code. `done` stays low, and no register output changes. `trap_code` is 0 whenever `trap_valid` is low.
- R9: On a successful exit, the block pulses `done` for one cycle and loads the following values. `x_out` and `sta_out` take the saved index and status words. `q_out` becomes Q minus the Q offset word. `s_out` becomes S minus 4 minus N. `p_out` becomes the return address.
- R10: A `start` pulse that arrives while an exit is in progress is ignored and does not alter that exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exit; all other inputs are latched with it |
| user_mode | input | 1 | Caller runs in user mode |
| seg_priv | input | 1 | Return segment entry is privileged |
| seg_absent | input | 1 | Return segment is not present |
| n_parm | input | NW | Number of parameter words to discard |
| cur_q | input | W | Current Q (marker top) |
| cur_s | input | W | Current S |
| cur_p | input | W | Current P |
| bound_lo | input | W | Lowest legal return address |
| bound_hi | input | W | Highest legal return address |
| mk_req | output | 1 | Marker read request |
| mk_addr | output | W | Marker word address |
| mk_ack | input | 1 | Read data valid this cycle |
| mk_data | input | W | Marker word read data |
| ref_mark | output | 1 | Set the reference bit of the segment entry |
| q_out | output | W | Q register |
| s_out | output | W | S register |
| p_out | output | W | P register |
| sta_out | output | W | Status register |
| x_out | output | W | Index register |
| done | output | 1 | Successful exit committed |
| trap_valid | output | 1 | Trap raised |
| trap_code | output | 3 | 1 privilege, 2 absent, 3 trace, 4 bounds |

## Verification
The bench sweeps every combination of mode, privilege, absence and trace flags against six return-address cases. The cases include a return landing exactly on each bound, one past each bound, and a subtraction that wraps past zero. A design with a wrong priority order would report the wrong code whenever two conditions overlap. An exclusive bound compare would trap on the edge cases, and a wrong treatment of the flag bit would misplace P. The bench also checks that the registers stay unchanged on every trapped exit, so a premature commit shows up as changed outputs. Random read stalls and a second start pulse during the fetch expose address slips and restarted sequences.

// File: rtl/exit_pkg.sv
package exit_pkg;

    localparam int MARKER_WORDS = 4;
    localparam int MK_X  = 0;
    localparam int MK_DP = 1;
    localparam int MK_ST = 2;
    localparam int MK_DQ = 3;

    typedef enum logic [2:0] {
        TRAP_NONE   = 3'd0,
        TRAP_PRIV   = 3'd1,
        TRAP_ABSENT = 3'd2,
        TRAP_TRACE  = 3'd3,
        TRAP_BOUNDS = 3'd4
    } trap_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK
    } state_e;

    function automatic trap_e pick_trap(input logic priv_bad,
                                        input logic absent,
                                        input logic trace,
                                        input logic oob);
        trap_e t;
        if (priv_bad)     t = TRAP_PRIV;
        else if (absent)  t = TRAP_ABSENT;
        else if (trace)   t = TRAP_TRACE;
        else if (oob)     t = TRAP_BOUNDS;
        else              t = TRAP_NONE;
        return t;
    endfunction

endpackage

// File: rtl/marker_reader.sv
module marker_reader
    import exit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              go,
    input  logic [W-1:0]                      top_q,
    input  logic                              mk_ack,
    input  logic [W-1:0]                      mk_data,
    output logic                              mk_req,
    output logic [W-1:0]                      mk_addr,
    output logic                              all_read,
    output logic [MARKER_WORDS-1:0][W-1:0]    words
);
    localparam int IDXW = $clog2(MARKER_WORDS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MARKER_WORDS - 1);

    logic            active;
    logic [IDXW-1:0] idx;
    logic [W-1:0]    base;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            base     <= '0;
            all_read <= 1'b0;
        end else begin
            all_read <= 1'b0;
            if (go) begin
                active <= 1'b1;
                idx    <= '0;
                base   <= top_q - W'(MARKER_WORDS - 1);
            end else if (active && mk_ack) begin
                if (idx == LAST_IDX) begin
                    active   <= 1'b0;
                    all_read <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < MARKER_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (active && mk_ack && idx == IDXW'(g))
                words[g] <= mk_data;
        end
    end

    assign mk_req  = active;
    assign mk_addr = base + W'(idx);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mk_req && !mk_ack) |=> (mk_req && $stable(mk_addr)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mk_req && mk_ack && !go && idx != LAST_IDX) |=> (mk_req && mk_addr == $past(mk_addr) + 1'b1));

endmodule

// File: rtl/exit_checker.sv
module exit_checker
    import exit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         user,
    input  logic         priv,
    input  logic         absent,
    input  logic [W-1:0] dp_word,
    input  logic [W-1:0] p_now,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] ret_p,
    output trap_e        code
);
    logic [W-1:0] offset;
    logic         trace;
    logic         below;
    logic         above;

    always_comb begin
        offset = {1'b0, dp_word[W-2:0]};
        trace  = dp_word[W-1];
        ret_p  = p_now - offset;
        below  = ret_p < lo;
        above  = ret_p > hi;
        code   = pick_trap(user && priv, absent, trace, below || above);
    end

endmodule

// File: rtl/exit_commit.sv
module exit_commit
    import exit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  trap_e        code,
    input  logic [W-1:0] q_new,
    input  logic [W-1:0] s_new,
    input  logic [W-1:0] p_new,
    input  logic [W-1:0] st_new,
    input  logic [W-1:0] x_new,
    output logic [W-1:0] q_out,
    output logic [W-1:0] s_out,
    output logic [W-1:0] p_out,
    output logic [W-1:0] sta_out,
    output logic [W-1:0] x_out,
    output logic         done,
    output logic         trap_valid,
    output logic [2:0]   trap_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_out      <= '0;
            s_out      <= '0;
            p_out      <= '0;
            sta_out    <= '0;
            x_out      <= '0;
            done       <= 1'b0;
            trap_valid <= 1'b0;
            trap_code  <= 3'd0;
        end else begin
            done       <= 1'b0;
            trap_valid <= 1'b0;
            trap_code  <= 3'd0;
            if (fire) begin
                if (code == TRAP_NONE) begin
                    q_out   <= q_new;
                    s_out   <= s_new;
                    p_out   <= p_new;
                    sta_out <= st_new;
                    x_out   <= x_new;
                    done    <= 1'b1;
                end else begin
                    trap_valid <= 1'b1;
                    trap_code  <= code;
                end
            end
        end
    end

    assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && trap_valid));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> ($stable(q_out) && $stable(s_out) && $stable(p_out)
                        && $stable(sta_out) && $stable(x_out)));

    assert_code_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> trap_code == 3'd0);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/proc_exit_seq.sv
module proc_exit_seq
    import exit_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          user_mode,
    input  logic          seg_priv,
    input  logic          seg_absent,
    input  logic [NW-1:0] n_parm,
    input  logic [W-1:0]  cur_q,
    input  logic [W-1:0]  cur_s,
    input  logic [W-1:0]  cur_p,
    input  logic [W-1:0]  bound_lo,
    input  logic [W-1:0]  bound_hi,
    output logic          mk_req,
    output logic [W-1:0]  mk_addr,
    input  logic          mk_ack,
    input  logic [W-1:0]  mk_data,
    output logic          ref_mark,
    output logic [W-1:0]  q_out,
    output logic [W-1:0]  s_out,
    output logic [W-1:0]  p_out,
    output logic [W-1:0]  sta_out,
    output logic [W-1:0]  x_out,
    output logic          done,
    output logic          trap_valid,
    output logic [2:0]    trap_code
);
    typedef struct packed {
        logic          user;
        logic          priv;
        logic          absent;
        logic [NW-1:0] n;
        logic [W-1:0]  q;
        logic [W-1:0]  s;
        logic [W-1:0]  p;
        logic [W-1:0]  lo;
        logic [W-1:0]  hi;
    } ctx_t;

    state_e                           state;
    ctx_t                             ctx;
    logic                             go;
    logic                             all_read;
    logic [MARKER_WORDS-1:0][W-1:0]   words;
    logic [W-1:0]                     ret_p;
    trap_e                            code;
    logic [W-1:0]                     q_new;
    logic [W-1:0]                     s_new;

    assign go       = (state == ST_IDLE) && start;
    assign ref_mark = (state == ST_CHECK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_READ;
                    ctx.user   <= user_mode;
                    ctx.priv   <= seg_priv;
                    ctx.absent <= seg_absent;
                    ctx.n      <= n_parm;
                    ctx.q      <= cur_q;
                    ctx.s      <= cur_s;
                    ctx.p      <= cur_p;
                    ctx.lo     <= bound_lo;
                    ctx.hi     <= bound_hi;
                end
                ST_READ:  if (all_read) state <= ST_CHECK;
                ST_CHECK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    marker_reader #(.W(W)) u_reader (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .top_q    (cur_q),
        .mk_ack   (mk_ack),
        .mk_data  (mk_data),
        .mk_req   (mk_req),
        .mk_addr  (mk_addr),
        .all_read (all_read),
        .words    (words)
    );

    exit_checker #(.W(W)) u_check (
        .user    (ctx.user),
        .priv    (ctx.priv),
        .absent  (ctx.absent),
        .dp_word (words[MK_DP]),
        .p_now   (ctx.p),
        .lo      (ctx.lo),
        .hi      (ctx.hi),
        .ret_p   (ret_p),
        .code    (code)
    );

    assign q_new = ctx.q - words[MK_DQ];
    assign s_new = ctx.s - W'(MARKER_WORDS) - {{(W-NW){1'b0}}, ctx.n};

    exit_commit #(.W(W)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .fire       (state == ST_CHECK),
        .code       (code),
        .q_new      (q_new),
        .s_new      (s_new),
        .p_new      (ret_p),
        .st_new     (words[MK_ST]),
        .x_new      (words[MK_X]),
        .q_out      (q_out),
        .s_out      (s_out),
        .p_out      (p_out),
        .sta_out    (sta_out),
        .x_out      (x_out),
        .done       (done),
        .trap_valid (trap_valid),
        .trap_code  (trap_code)
    );

    assert_priv_first_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_mark && ctx.user && ctx.priv) |=> (trap_valid && trap_code == 3'd1));

    assert_ref_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ref_mark |=> !ref_mark);

    assert_ref_before_end_R7: assert property (@(posedge clk) disable iff (rst)
        ref_mark |=> (done || trap_valid));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !mk_req);

endmodule

// File: tb/tb_proc_exit_seq.sv
module tb_proc_exit_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          user_mode = 1'b0, seg_priv = 1'b0, seg_absent = 1'b0;
    logic [NW-1:0] n_parm = '0;
    logic [W-1:0]  cur_q = '0, cur_s = '0, cur_p = '0, bound_lo = '0, bound_hi = '0;
    logic          mk_req;
    logic [W-1:0]  mk_addr;
    logic          mk_ack = 1'b0;
    logic [W-1:0]  mk_data = '0;
    logic          ref_mark;
    logic [W-1:0]  q_out, s_out, p_out, sta_out, x_out;
    logic          done, trap_valid;
    logic [2:0]    trap_code;

    proc_exit_seq #(.W(W), .NW(NW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [W-1:0] mkw [4];
    logic [W-1:0] exp_q_base;
    int k = 0;
    int addr_err = 0;
    int ref_cnt = 0;

    logic [W-1:0] m_q = '0, m_s = '0, m_p = '0, m_st = '0, m_x = '0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            summary();
        end
    end

    // Marker memory model with stalls; also checks read addresses (R2)
    always @(negedge clk) begin
        if (mk_ack) k = k + 1;
        if (mk_req) begin
            if (k > 3 || mk_addr != exp_q_base - 16'd3 + W'(k)) addr_err = addr_err + 1;
            mk_ack  = (k < 4) && ((cyc % 3) != 1);
            mk_data = (k < 4) ? mkw[k] : '0;
        end else begin
            mk_ack = 1'b0;
        end
        if (ref_mark) ref_cnt = ref_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_exit(input bit u, input bit pv, input bit ab, input bit tr,
                            input logic [W-1:0] q, input logic [W-1:0] s,
                            input logic [W-1:0] p, input logic [W-1:0] dpoff,
                            input logic [NW-1:0] n, input bit restart);
        logic [W-1:0] ret;
        logic [2:0]   ecode;
        bit           seen;
        int           extra;
        mkw[0] = 16'h1000 ^ q;
        mkw[1] = {tr, dpoff[W-2:0]};
        mkw[2] = 16'h2000 + s;
        mkw[3] = 16'd7 + {8'd0, n};
        ret = p - {1'b0, dpoff[W-2:0]};
        if (u && pv)                          ecode = 3'd1;
        else if (ab)                          ecode = 3'd2;
        else if (tr)                          ecode = 3'd3;
        else if (ret < 16'd100 || ret > 16'd200) ecode = 3'd4;
        else                                  ecode = 3'd0;

        @(negedge clk);
        k = 0; addr_err = 0; ref_cnt = 0;
        exp_q_base = q;
        user_mode = u; seg_priv = pv; seg_absent = ab;
        cur_q = q; cur_s = s; cur_p = p; n_parm = n;
        bound_lo = 16'd100; bound_hi = 16'd200;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            if (restart && i == 2) begin
                // R10: second start mid-fetch with different operands
                cur_q = q + 16'h0100; cur_p = 16'd0; user_mode = 1'b1; seg_priv = 1'b1;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done || trap_valid) seen = 1'b1;
        end
        start = 1'b0;
        check(seen, "R8", "exit completion", seen, 1);
        if (ecode == 3'd0) begin
            check(done && !trap_valid, "R9", "done pulse", {done, trap_valid}, 2'b10);
            m_q = q - mkw[3]; m_s = s - 16'd4 - {8'd0, n}; m_p = ret;
            m_st = mkw[2]; m_x = mkw[0];
        end else begin
            check(trap_valid && !done && trap_code == ecode,
                  ecode == 1 ? "R3" : ecode == 2 ? "R4" : ecode == 3 ? "R5" : "R6",
                  "trap code", {done, trap_valid, trap_code}, {2'b01, ecode});
        end
        check(q_out == m_q && s_out == m_s && p_out == m_p && sta_out == m_st && x_out == m_x,
              ecode == 0 ? "R9" : "R8", "register outputs",
              {q_out, s_out, p_out, sta_out}, {m_q, m_s, m_p, m_st});
        check(ref_cnt == 1, "R7", "ref_mark pulses", ref_cnt, 1);
        check(addr_err == 0 && k == 4, "R2", "marker addresses", addr_err, 0);
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done || trap_valid || mk_req) extra = extra + 1;
        end
        check(extra == 0, restart ? "R10" : "R8", "quiet after exit", extra, 0);
    endtask

    initial begin
        logic [W-1:0] pcase [6];
        logic [W-1:0] dcase [6];
        pcase = '{16'd300, 16'd300, 16'd300, 16'd300, 16'd300, 16'd5};
        dcase = '{16'd150, 16'd201, 16'd99, 16'd200, 16'd100, 16'd10};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(q_out == 0 && s_out == 0 && p_out == 0 && sta_out == 0 && x_out == 0,
              "R1", "reset registers", {q_out, s_out, p_out}, 0);
        check(!mk_req && !ref_mark && !done && !trap_valid, "R1", "reset controls",
              {mk_req, ref_mark, done, trap_valid}, 0);

        for (int u = 0; u < 2; u++)
            for (int pv = 0; pv < 2; pv++)
                for (int ab = 0; ab < 2; ab++)
                    for (int tr = 0; tr < 2; tr++)
                        for (int b = 0; b < 6; b++)
                            run_exit(u[0], pv[0], ab[0], tr[0],
                                     16'h0400 + W'(b * 13 + u * 5),
                                     16'h0800 + W'(b * 7),
                                     pcase[b], dcase[b],
                                     NW'(b * 37 + tr * 11 + ab), 1'b0);

        // R10: start during fetch is ignored
        run_exit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0500, 16'h0900, 16'd300, 16'd150, 8'd3, 1'b1);
        // N at its maximum, Q near zero to wrap the marker address (R2, R9)
        run_exit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0100, 16'd250, 16'd120, 8'hFF, 1'b0);

        finished = 1'b1;
        summary();
    end
endmodule